// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block takes a set of interrupt request lines and decides, every cycle, whether the processor should be interrupted and which line is the cause. It keeps three per-line registers: requests that have been captured, lines that are masked, and lines whose service is in progress. A fourth per-line register selects the trigger mode. Each input is sampled on the clock. An edge-mode line records only a new rising transition. A level-mode line copies the input level.

Priority is relative to a programmable base line. The base line has rank 0, the next line upward (wrapping) has rank 1, and so on. The unmasked pending request with the lowest rank is compared against the lowest rank among in-service lines. The interrupt output is raised only when the pending request ranks strictly better. Two optional exclusions apply before that comparison. Special mask mode drops masked lines from the in-service set. Nested mode, on a master instance, drops the cascade line from the in-service set.

Configuration writes (trigger mode, mask and base line) and acknowledge/end-of-service strobes are plain one-cycle inputs from the surrounding controller. The request and in-service registers are visible on output ports.

Top module: `irq_rotating_resolver`

## Requirements
- R1: After a synchronous active-low reset, the request, in-service, mask and previous-level registers are all zero, the base line is 0, every line is in edge mode (trigger bit 0), and `int_req` is low.
- R2: A line whose trigger bit is 1 (level mode) has its request bit equal to the input level sampled at the previous clock edge, whether or not it is acknowledged.
- R3: A line whose trigger bit is 0 (edge mode) sets its request bit at the first clock edge that sees the input high after a low sample. A falling or steady input never clears the bit.
- R4: An acknowledge strobe on an edge-mode line clears its request bit, unless a new rising edge is seen in the same cycle. A line held high does not re-request after acknowledge. An acknowledge never clears a level-mode request.
- R5: The pending set is request AND NOT mask. A masked request never raises `int_req`.
- R6: The rank of line L is (L − base) mod 8. Among pending lines the lowest rank wins, and `int_line` reports that line whenever `int_req` is high.
- R7: `int_req` is high exactly when the best pending rank is numerically smaller than the best in-service rank. An empty set counts as rank 8.
- R8: With `spec_mask_en` high, in-service lines that are masked are ignored when the in-service rank is formed.
- R9: With `nested_en` high on a master instance, an in-service bit on cascade line 2 is ignored when the in-service rank is formed.
- R10: An acknowledge bit sets the in-service bit at the next edge. An end-of-service bit clears it. When both strobes hit the same line, the set wins.
- R11: Mask, base and trigger writes take effect at the next clock edge. `int_req` and `int_line` follow the registers combinationally, in the same cycle as the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 8 | Raw interrupt request lines |
| trig_we | input | 1 | Load the trigger-mode register |
| trig_din | input | 8 | Trigger modes, 1 = level, 0 = edge |
| mask_we | input | 1 | Load the mask register |
| mask_din | input | 8 | Mask bits, 1 = masked |
| base_we | input | 1 | Load the priority base line |
| base_din | input | 3 | Line that gets rank 0 |
| ack_set | input | 8 | Per-line acknowledge strobe |
| eoi_clr | input | 8 | Per-line end-of-service strobe |
| spec_mask_en | input | 1 | Special mask mode enable |
| nested_en | input | 1 | Nested mode enable (cascade exclusion) |
| int_req | output | 1 | Interrupt to the processor |
| int_line | output | 3 | Winning line while int_req is high |
| req_bits | output | 8 | Request register |
| svc_bits | output | 8 | In-service register |

## Verification
The sweep runs every base line against many mixes of request, mask and in-service patterns under all four mode combinations. It exposes wrap-around errors in the rank arithmetic: a design that searched from line 0, or rotated the wrong way, would name the wrong winner. It also catches a non-strict comparison, which would re-interrupt a line already in service. Directed edge sequences go after a design that clears a request on a falling input, re-requests while the input stays high after acknowledge, or lets an acknowledge wipe a level request. The mode sweep also flags exclusions that are missing or applied to the wrong set: a masked line blocking lower ranks under special mask mode, or the cascade line blocking under nested mode.

// File: rtl/irq_res_pkg.sv
// Shared definitions for the rotating-priority interrupt resolver.
// Assumes: nothing beyond IEEE 1800-2017.
package irq_res_pkg;
    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

    // Wrap a sum into the range 0..n-1 (operands are each below n).
    function automatic int wrap_idx(input int a, input int b, input int n);
        int s;
        s = a + b;
        if (s >= n) s = s - n;
        return s;
    endfunction
endpackage

// File: rtl/irq_line_capture.sv
// One request line: turns the raw input into a request bit.
// Level mode copies the input; edge mode latches a rising transition
// against a stored previous level. Acknowledge clears edge-mode
// requests only. Assumes the input is already synchronous to clk.
module irq_line_capture
    import irq_res_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       din,
    input  trig_mode_e mode,
    input  logic       ack,
    output logic       req_q
);
    logic last_q;

    // Track the previous sampled level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= din;
    end

    // Update the request bit according to the trigger mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (mode == TRIG_LEVEL) begin
            req_q <= din;
        end else if (din && !last_q) begin
            req_q <= 1'b1;
        end else if (ack) begin
            req_q <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_rank_finder.sv
// Finds the best rank in a bit vector, where position p maps to bit
// (p + base) mod N and position 0 is best. An empty vector yields N.
// Purely combinational. Assumes base < N.
module irq_rank_finder
    import irq_res_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = $clog2(N),
    parameter int RW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    input  logic [IW-1:0] base,
    output logic [RW-1:0] rank
);
    // Scan from the worst position down so the best set one is left.
    always_comb begin
        rank = RW'(N);
        for (int p = N - 1; p >= 0; p--) begin
            if (vec[wrap_idx(p, int'(base), N)]) rank = RW'(p);
        end
    end
endmodule

// File: rtl/irq_rotating_resolver.sv
// Top of the resolver: holds trigger, mask, base and in-service state,
// captures requests per line, and compares the best pending rank to
// the best in-service rank to drive int_req / int_line.
// Assumes all strobes are single-cycle and synchronous to clk.
module irq_rotating_resolver
    import irq_res_pkg::*;
#(
    parameter int N         = 8,
    parameter bit IS_MASTER = 1'b1,
    parameter int CASC_LINE = 2,
    localparam int IW       = $clog2(N),
    localparam int RW       = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_in,
    input  logic          trig_we,
    input  logic [N-1:0]  trig_din,
    input  logic          mask_we,
    input  logic [N-1:0]  mask_din,
    input  logic          base_we,
    input  logic [IW-1:0] base_din,
    input  logic [N-1:0]  ack_set,
    input  logic [N-1:0]  eoi_clr,
    input  logic          spec_mask_en,
    input  logic          nested_en,
    output logic          int_req,
    output logic [IW-1:0] int_line,
    output logic [N-1:0]  req_bits,
    output logic [N-1:0]  svc_bits
);
    logic [N-1:0]  trig_q;
    logic [N-1:0]  mask_q;
    logic [IW-1:0] base_q;
    logic [N-1:0]  isr_q;
    logic [N-1:0]  irr_q;
    logic [N-1:0]  pend_vec;
    logic [N-1:0]  svc_vec;
    logic [N-1:0]  casc_keep;
    logic [RW-1:0] pend_rank;
    logic [RW-1:0] svc_rank;

    // Configuration registers: trigger modes, mask and base line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= '0;
            mask_q <= '0;
            base_q <= '0;
        end else begin
            if (trig_we) trig_q <= trig_din;
            if (mask_we) mask_q <= mask_din;
            if (base_we) base_q <= base_din;
        end
    end

    // In-service register: clear on end-of-service, then set on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~eoi_clr) | ack_set;
    end

    // One capture cell per request line.
    for (genvar g = 0; g < N; g++) begin : g_line
        irq_line_capture u_cap (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (irq_in[g]),
            .mode  (trig_mode_e'(trig_q[g])),
            .ack   (ack_set[g]),
            .req_q (irr_q[g])
        );
    end

    // Cascade exclusion only exists on a master instance.
    if (IS_MASTER) begin : g_master
        always_comb begin
            casc_keep = '1;
            if (nested_en) casc_keep[CASC_LINE] = 1'b0;
        end
    end else begin : g_slave
        assign casc_keep = '1;
    end

    // Form the pending set and the effective in-service set.
    always_comb begin
        pend_vec = irr_q & ~mask_q;
        svc_vec  = isr_q & casc_keep;
        if (spec_mask_en) svc_vec = svc_vec & ~mask_q;
    end

    irq_rank_finder #(.N(N)) u_pend_rank (
        .vec  (pend_vec),
        .base (base_q),
        .rank (pend_rank)
    );

    irq_rank_finder #(.N(N)) u_svc_rank (
        .vec  (svc_vec),
        .base (base_q),
        .rank (svc_rank)
    );

    // Raise only on a strictly better pending rank; map rank back to line.
    always_comb begin
        int_req  = (pend_rank < svc_rank);
        int_line = IW'(wrap_idx(int'(pend_rank) % N, int'(base_q), N));
    end

    assign req_bits = irr_q;
    assign svc_bits = isr_q;
endmodule

// File: rtl/irq_rotating_resolver_chk.sv
// Property checker for the resolver, attached by bind below.
// Assumes the default 8-line configuration with cascade line 2.
module irq_rotating_resolver_chk #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  irq_in,
    input logic [N-1:0]  trig_q,
    input logic [N-1:0]  mask_q,
    input logic [N-1:0]  ack_set,
    input logic [N-1:0]  eoi_clr,
    input logic          nested_en,
    input logic          int_req,
    input logic [IW-1:0] int_line,
    input logic [N-1:0]  irr_q,
    input logic [N-1:0]  isr_q
);
    // R5: the reported winner is a real, unmasked request.
    assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (irr_q[int_line] && !mask_q[int_line]));

    // R2: level-mode request bits track the sampled input.
    assert_level_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((irr_q ^ $past(irq_in)) & $past(trig_q)) == '0));

    // R3: an edge-mode request is held unless acknowledged.
    assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(irr_q) & ~$past(trig_q) & ~$past(ack_set)) & ~irr_q) == '0));

    // R10: acknowledge always leaves the in-service bit set.
    assert_ack_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((isr_q & $past(ack_set)) == $past(ack_set)));

    // R10: end-of-service without acknowledge clears the bit.
    assert_eoi_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((isr_q & $past(eoi_clr) & ~$past(ack_set)) == '0));

    // R7: a line already in service is never re-signalled (cascade aside).
    assert_strict_rank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && !(nested_en && int_line == IW'(2))) |-> !isr_q[int_line]);
endmodule

bind irq_rotating_resolver irq_rotating_resolver_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .trig_q    (trig_q),
    .mask_q    (mask_q),
    .ack_set   (ack_set),
    .eoi_clr   (eoi_clr),
    .nested_en (nested_en),
    .int_req   (int_req),
    .int_line  (int_line),
    .irr_q     (irr_q),
    .isr_q     (isr_q)
);

// File: tb/irq_rotating_resolver_tb.sv
module irq_rotating_resolver_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0, trig_din = '0, mask_din = '0, ack_set = '0, eoi_clr = '0;
    logic       trig_we = 1'b0, mask_we = 1'b0, base_we = 1'b0;
    logic [2:0] base_din = '0;
    logic       spec_mask_en = 1'b0, nested_en = 1'b0;
    logic       int_req;
    logic [2:0] int_line;
    logic [7:0] req_bits, svc_bits;
    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_rotating_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig_we(trig_we),
        .trig_din(trig_din), .mask_we(mask_we), .mask_din(mask_din),
        .base_we(base_we), .base_din(base_din), .ack_set(ack_set),
        .eoi_clr(eoi_clr), .spec_mask_en(spec_mask_en), .nested_en(nested_en),
        .int_req(int_req), .int_line(int_line), .req_bits(req_bits),
        .svc_bits(svc_bits)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, then sample just after the next rising edge.
    task automatic step();
        @(posedge clk);
        #1;
        @(negedge clk);
        trig_we = 0; mask_we = 0; base_we = 0; ack_set = '0; eoi_clr = '0;
    endtask

    // Lowest rank among set bits; rank of line L is (L - base) mod 8; empty = 8.
    function automatic int best(input logic [7:0] v, input int b);
        int r = 8;
        for (int l = 0; l < 8; l++)
            if (v[l] && ((l - b + 8) % 8) < r) r = (l - b + 8) % 8;
        return r;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 req_bits", req_bits, 0);
        chk("R1 svc_bits", svc_bits, 0);
        chk("R1 int_req", int_req, 0);

        // R1: edge mode by default; mask clear and base 0 after reset.
        irq_in = 8'h01; step();
        chk("R1 edge default capture", req_bits, 8'h01);
        chk("R1 mask clear req", int_req, 1);
        chk("R1 base zero line", int_line, 0);
        ack_set = 8'h01; irq_in = 0; step();
        eoi_clr = 8'hFF; step();

        // R3/R4: line 3 edge, all others level.
        trig_we = 1; trig_din = 8'hF7; step();
        irq_in = 8'h08; step();
        chk("R3 rising sets", req_bits[3], 1);
        irq_in = 8'h00; step();
        chk("R3 fall keeps", req_bits[3], 1);
        irq_in = 8'h08; step();
        ack_set = 8'h08; step();
        chk("R4 ack clears edge", req_bits[3], 0);
        chk("R10 ack sets svc", svc_bits[3], 1);
        step();
        chk("R4 held high no rerequest", req_bits[3], 0);
        irq_in = 8'h00; step();
        irq_in = 8'h08; step();
        chk("R3 new edge sets", req_bits[3], 1);
        irq_in = 8'h08; ack_set = 8'h08; eoi_clr = 8'hFF; step();
        irq_in = 8'h00; eoi_clr = 8'hFF; step();

        // R2/R4/R10 on level line 5.
        irq_in = 8'h20; step();
        chk("R2 level high", req_bits[5], 1);
        ack_set = 8'h20; step();
        chk("R4 ack keeps level", req_bits[5], 1);
        irq_in = 8'h00; step();
        chk("R2 level low clears", req_bits[5], 0);
        ack_set = 8'h20; eoi_clr = 8'h20; step();
        chk("R10 set wins", svc_bits[5], 1);
        eoi_clr = 8'h20; step();
        chk("R10 eoi clears", svc_bits[5], 0);

        // Sweep: all level; every base, many patterns, all mode pairs.
        trig_we = 1; trig_din = 8'hFF; step();
        for (int b = 0; b < 8; b++) begin
            for (int i = 0; i < 64; i++) begin
                logic [7:0] a, m, c, pend, svc;
                int pb, pc, el;
                bit ereq, sm, ne;
                a  = 8'((i * 73 + b * 29 + 17) ^ (i >> 1));
                m  = 8'((i * 151 + b * 7) & ((i % 3 == 0) ? 8'h00 : 8'hFF)) & 8'(i * 37 + 5);
                c  = 8'(i * 89 + b * 53) & 8'(i * 43 + 11) & 8'(i * 23 + 3);
                sm = i[0]; ne = i[1];
                irq_in = a; mask_we = 1; mask_din = m; base_we = 1; base_din = 3'(b);
                eoi_clr = 8'hFF; ack_set = c; spec_mask_en = sm; nested_en = ne;
                @(posedge clk); #1;
                pend = a & ~m;
                svc = c;
                if (sm) svc = svc & ~m;
                if (ne) svc = svc & 8'hFB;
                pb = best(pend, b);
                pc = best(svc, b);
                ereq = (pb < pc);
                el = (pb + b) % 8;
                chk("R2 sweep req_bits", req_bits, a);
                chk("R10 sweep svc_bits", svc_bits, c);
                if (sm || ne) chk("R8 R9 sweep int_req", int_req, ereq);
                else          chk("R5 R7 R11 sweep int_req", int_req, ereq);
                if (ereq) chk("R6 sweep int_line", int_line, el);
                @(negedge clk);
                mask_we = 0; base_we = 0; ack_set = '0; eoi_clr = '0;
            end
        end

        // R9: directed cascade case, base 0, line 2 in service, line 2 pending.
        irq_in = 8'h04; mask_we = 1; mask_din = 0; base_we = 1; base_din = 0;
        eoi_clr = 8'hFF; ack_set = 8'h04; nested_en = 1; spec_mask_en = 0; step();
        chk("R9 cascade ignored", int_req, 1);
        nested_en = 0; #1;
        chk("R7 equal rank blocked", int_req, 0);
        // R8: masked in-service line 0 under special mask lets line 4 through.
        irq_in = 8'h10; mask_we = 1; mask_din = 8'h01; eoi_clr = 8'hFF; ack_set = 8'h01;
        spec_mask_en = 1; step();
        chk("R8 special mask req", int_req, 1);
        chk("R8 special mask line", int_line, 4);
        spec_mask_en = 0; #1;
        chk("R8 off blocks", int_req, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule